// File: doc/BRIEF.md
# Dual-Address I2C Slave Port Controller

This block is an I2C slave that responds at two 7-bit addresses. Both addresses share a 4-bit strap value as their low bits. A fixed upper code `110` selects the 8-bit input port and `101` selects the 8-bit push-pull output port. SCL and SDA are oversampled on the system clock. The block detects START and STOP, shifts bytes MSB first, and pulls SDA low through an open-drain enable to acknowledge and to send read data.

Writes to the output address load the output latches. Writes to the input address load the interrupt mask. Reads of the input address alternate between a fresh port snapshot and the transition flags that a separate change-detection block supplies. Each snapshot pulses strobes that this neighbour uses to clear and re-arm its flags. Reads of the output address return the pin levels, read back as inputs, on every byte.

Top module: `dual_port_i2c_slave`

## Requirements
- R1: During and after reset, before any transfer, `sda_oe` is 0, `out_latch` is 8'hFF and `int_mask` is 8'h00.
- R2: A STOP (SDA rising while SCL is high) ends the transfer, and clocked bits are then ignored until a START. A START (SDA falling while SCL is high) begins address reception at any time, including as a repeated START inside a transfer.
- R3: The first byte after a START is taken as address[6:0] followed by R/W (0 = write, 1 = read). When the address equals {3'b110, strap} or {3'b101, strap}, the block holds SDA low for the whole high phase of the 9th clock.
- R4: When the address does not match, the block never pulls SDA low until the next START.
- R5: Every data byte written to the output address loads all eight `out_latch` bits and is acknowledged on the 9th clock.
- R6: Every data byte written to the input address loads `int_mask`, leaves `out_latch` unchanged, pulses `flag_clr` once, and is acknowledged.
- R7: In a read of the input address, even-numbered bytes (counting from 0) return `in_port`, sampled when that byte is loaded. Odd-numbered bytes return the `trans_flags` captured together with the snapshot just before. Each snapshot pulses `snap_strobe` and `flag_clr` once.
- R8: In a read of the output address, every byte returns `out_pin_lvl` as it is when that byte is loaded.
- R9: After the master leaves the 9th bit of a read byte high (NACK), the block releases SDA and does not drive it again until the next START.
- R10: `sda_oe` changes only while the synchronized SCL is low, except for the release caused by a START or a STOP.
- R11: Bits are transferred MSB first on both the receive and the transmit paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | 4 | Low four address bits shared by both addresses |
| in_port | input | 8 | Input port pin levels |
| trans_flags | input | 8 | Transition flags from the change-detection block |
| out_pin_lvl | input | 8 | Output pin levels, read back as inputs |
| out_latch | output | 8 | Push-pull output latch value |
| int_mask | output | 8 | Interrupt mask register |
| snap_strobe | output | 1 | One-cycle pulse when the input port is sampled for a read |
| flag_clr | output | 1 | One-cycle pulse asking the change-detection block to clear its flags |

## Verification
The hardest behaviour to reach from the ports is the byte-by-byte alternation of a multi-byte input read. In that read, the flag byte must carry the values captured with the earlier snapshot, while the next port byte must carry a new sample. The stimulus changes `in_port` and `trans_flags` between data bytes, in the window after the master's acknowledge and before the block loads the next byte. The returned values then show which capture each byte came from. Quiet behaviour after an address mismatch and after a master NACK is reached by continuing to clock full bytes with SDA released, while the bench watches `sda_oe` throughout.

// File: rtl/dpi2c_pkg.sv
package dpi2c_pkg;
    localparam int BYTE_W = 8;
    localparam int STRAP_W = 4;
    localparam logic [2:0] IN_TAG  = 3'b110;
    localparam logic [2:0] OUT_TAG = 3'b101;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGNORE
    } xfer_state_e;

    typedef enum logic [1:0] {SEL_NONE, SEL_IN, SEL_OUT} port_sel_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic port_sel_e decode_addr(input logic [6:0] a, input logic [STRAP_W-1:0] strap);
        if (a == {IN_TAG, strap})
            return SEL_IN;
        else if (a == {OUT_TAG, strap})
            return SEL_OUT;
        return SEL_NONE;
    endfunction
endpackage

// File: rtl/dpi2c_line_cond.sv
module dpi2c_line_cond
    import dpi2c_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [SYNC-1:0] scl_p, sda_p;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[SYNC-2:0], scl_in};
            sda_p <= {sda_p[SYNC-2:0], sda_in};
            scl_q <= scl_p[SYNC-1];
            sda_q <= sda_p[SYNC-1];
        end
    end

    always_comb begin
        ev.scl      = scl_p[SYNC-1];
        ev.sda      = sda_p[SYNC-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end

    // R2: a START and a STOP can never be reported in the same cycle
    p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));
endmodule

// File: rtl/dpi2c_port_regs.sv
module dpi2c_port_regs
    import dpi2c_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OUT_RST  = 8'hFF,
    parameter logic [BYTE_W-1:0] MASK_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_out,
    input  logic              ld_mask,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] out_latch,
    output logic [BYTE_W-1:0] int_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_latch <= OUT_RST;
            int_mask  <= MASK_RST;
        end else begin
            if (ld_out)
                out_latch <= wbyte;
            if (ld_mask)
                int_mask <= wbyte;
        end
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (out_latch == OUT_RST && int_mask == MASK_RST));
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ld_out |=> $stable(out_latch));
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !ld_mask |=> $stable(int_mask));
endmodule

// File: rtl/dual_port_i2c_slave.sv
module dual_port_i2c_slave
    import dpi2c_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic [7:0] OUT_RST  = 8'hFF,
    parameter logic [7:0] MASK_RST = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [3:0] addr_strap,
    input  logic [7:0] in_port,
    input  logic [7:0] trans_flags,
    input  logic [7:0] out_pin_lvl,
    output logic [7:0] out_latch,
    output logic [7:0] int_mask,
    output logic       snap_strobe,
    output logic       flag_clr
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    line_ev_t    ev;
    xfer_state_e st;
    port_sel_e   sel, dec;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh, tx, nb, flag_hold, wbyte;
    logic rw, nack, flag_next, oe_q, snap_q, clr_q, ld_out, ld_mask;

    dpi2c_line_cond #(.SYNC(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i), .ev(ev)
    );

    dpi2c_port_regs #(.OUT_RST(OUT_RST), .MASK_RST(MASK_RST)) u_regs (
        .clk(clk), .rst(rst), .ld_out(ld_out), .ld_mask(ld_mask),
        .wbyte(wbyte), .out_latch(out_latch), .int_mask(int_mask)
    );

    assign dec = decode_addr(sh[7:1], addr_strap);

    always_comb begin
        if (sel == SEL_IN)
            nb = flag_next ? flag_hold : in_port;
        else
            nb = out_pin_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            sel <= SEL_NONE;
            cnt <= '0;
            sh <= '0;
            tx <= '0;
            flag_hold <= '0;
            wbyte <= '0;
            rw <= 1'b0;
            nack <= 1'b0;
            flag_next <= 1'b0;
            oe_q <= 1'b0;
            snap_q <= 1'b0;
            clr_q <= 1'b0;
            ld_out <= 1'b0;
            ld_mask <= 1'b0;
        end else begin
            snap_q <= 1'b0;
            clr_q <= 1'b0;
            ld_out <= 1'b0;
            ld_mask <= 1'b0;
            if (ev.start) begin
                st <= ST_ADDR;
                cnt <= '0;
                oe_q <= 1'b0;
            end else if (ev.stop) begin
                st <= ST_IDLE;
                oe_q <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            sh <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == LAST_BIT) begin
                            if (st == ST_WDATA) begin
                                wbyte <= sh;
                                ld_out <= (sel == SEL_OUT);
                                ld_mask <= (sel == SEL_IN);
                                clr_q <= (sel == SEL_IN);
                                oe_q <= 1'b1;
                                st <= ST_WACK;
                            end else if (dec == SEL_NONE) begin
                                st <= ST_IGNORE;
                            end else begin
                                sel <= dec;
                                rw <= sh[0];
                                oe_q <= 1'b1;
                                st <= ST_AACK;
                                flag_next <= 1'b0;
                                if (sh[0]) begin
                                    if (dec == SEL_IN) begin
                                        tx <= in_port;
                                        flag_hold <= trans_flags;
                                        snap_q <= 1'b1;
                                        clr_q <= 1'b1;
                                        flag_next <= 1'b1;
                                    end else begin
                                        tx <= out_pin_lvl;
                                    end
                                end
                            end
                        end
                    end
                    ST_AACK: if (ev.scl_fall) begin
                        if (rw) begin
                            oe_q <= ~tx[BYTE_W-1];
                            tx <= {tx[BYTE_W-2:0], 1'b0};
                            cnt <= CNT_W'(1);
                            st <= ST_RDATA;
                        end else begin
                            oe_q <= 1'b0;
                            cnt <= '0;
                            st <= ST_WDATA;
                        end
                    end
                    ST_WACK: if (ev.scl_fall) begin
                        oe_q <= 1'b0;
                        cnt <= '0;
                        st <= ST_WDATA;
                    end
                    ST_RDATA: if (ev.scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            oe_q <= 1'b0;
                            st <= ST_RACK;
                        end else begin
                            oe_q <= ~tx[BYTE_W-1];
                            tx <= {tx[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            nack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (nack) begin
                                st <= ST_IGNORE;
                            end else begin
                                oe_q <= ~nb[BYTE_W-1];
                                tx <= {nb[BYTE_W-2:0], 1'b0};
                                cnt <= CNT_W'(1);
                                st <= ST_RDATA;
                                if (sel == SEL_IN) begin
                                    flag_next <= ~flag_next;
                                    if (!flag_next) begin
                                        flag_hold <= trans_flags;
                                        snap_q <= 1'b1;
                                        clr_q <= 1'b1;
                                    end
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = oe_q;
    assign snap_strobe = snap_q;
    assign flag_clr = clr_q;

    // R10: the drive changes only after SCL was seen low, or on a START/STOP release
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> (!$past(ev.scl) || $past(ev.start) || $past(ev.stop)));
    p_ignore_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE) |-> !oe_q);
    p_start_release_r2: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_ADDR && !oe_q));
    p_addr_ack_held_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AACK) |-> oe_q);
    p_nack_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RACK) |-> !oe_q);
endmodule

// File: tb/tb_dual_port_i2c_slave.sv
module tb_dual_port_i2c_slave;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0] strap = 4'h0;
    logic [7:0] in_port = 8'h00, trans_flags = 8'h00, out_pin_lvl = 8'h00;
    logic sda_oe, snap_strobe, flag_clr;
    logic [7:0] out_latch, int_mask;
    logic sda_bus;

    int checks = 0, fails = 0, cyc = 0;
    int n_clr = 0, n_snap = 0, r10_viol = 0, quiet_hits = 0;
    logic quiet_win = 1'b0;
    logic oe_prev = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    dual_port_i2c_slave dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_strap(strap), .in_port(in_port), .trans_flags(trans_flags),
        .out_pin_lvl(out_pin_lvl), .out_latch(out_latch), .int_mask(int_mask),
        .snap_strobe(snap_strobe), .flag_clr(flag_clr)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (flag_clr) n_clr++;
            if (snap_strobe) n_snap++;
            if (sda_oe != oe_prev && scl_m) r10_viol++;
            if (quiet_win && sda_oe) quiet_hits++;
        end
        oe_prev = sda_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] addr_byte(input bit to_in, input logic [3:0] s, input bit rd);
        return {(to_in ? 3'b110 : 3'b101), s, rd};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic b, output logic s_first, output logic s_last);
        sda_m = b;
        repeat (H) @(negedge clk);
        scl_m = 1'b1;
        @(negedge clk);
        s_first = sda_bus;
        repeat (H - 1) @(negedge clk);
        s_last = sda_bus;
        scl_m = 1'b0;
        @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1;
        repeat (H) @(negedge clk);
        scl_m = 1'b1;
        repeat (H) @(negedge clk);
        sda_m = 1'b0;
        repeat (H) @(negedge clk);
        scl_m = 1'b0;
        @(negedge clk);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0;
        repeat (H) @(negedge clk);
        scl_m = 1'b1;
        repeat (H) @(negedge clk);
        sda_m = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] d, output bit ack);
        logic f, l;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], f, l);
        bit_xfer(1'b1, f, l);
        ack = !f && !l;
    endtask

    task automatic rd_byte(input bit m_ack, output logic [7:0] d);
        logic f, l;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, f, l);
            d[i] = l;
        end
        bit_xfer(!m_ack, f, l);
    endtask

    initial begin
        bit ack;
        logic [7:0] v, rb, pa, fa, pb, fb;
        int c0;
        void'($urandom(32'd2719));
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);
        chk(out_latch == 8'hFF, "R1 out_latch at reset", out_latch, 8'hFF);
        chk(int_mask == 8'h00, "R1 int_mask at reset", int_mask, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_latch == 8'hFF && int_mask == 8'h00 && !sda_oe, "R1 idle after reset",
            {out_latch, int_mask}, 16'hFF00);

        // R3 R5 R11: write several bytes to the output address
        strap = 4'($urandom);
        i2c_start();
        wr_byte(addr_byte(0, strap, 0), ack);
        chk(ack, "R3 output address ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            v = (k == 0) ? 8'h81 : 8'($urandom);
            wr_byte(v, ack);
            chk(ack, "R5 data ack", ack, 1);
            chk(out_latch == v, "R5 R11 out_latch load", out_latch, v);
        end
        i2c_stop();

        // R6: write the interrupt mask
        c0 = n_clr;
        v = out_latch;
        i2c_start();
        wr_byte(addr_byte(1, strap, 0), ack);
        chk(ack, "R3 input address ack", ack, 1);
        for (int k = 0; k < 2; k++) begin
            pa = 8'($urandom);
            wr_byte(pa, ack);
            chk(ack && int_mask == pa, "R6 int_mask load", int_mask, pa);
        end
        i2c_stop();
        chk(n_clr == c0 + 2, "R6 flag_clr pulses", n_clr - c0, 2);
        chk(out_latch == v, "R6 out_latch untouched", out_latch, v);

        // R2: bits after STOP without START are ignored
        wr_byte(addr_byte(0, strap, 0), ack);
        chk(!ack, "R2 no ack without START", ack, 0);

        // R4: mismatched address stays silent, then repeated START recovers (R2)
        v = out_latch;
        quiet_win = 1'b1;
        i2c_start();
        wr_byte({3'b110, strap ^ 4'h1, 1'b0}, ack);
        chk(!ack, "R4 mismatch not acked", ack, 0);
        wr_byte(8'h00, ack);
        quiet_win = 1'b0;
        chk(quiet_hits == 0, "R4 sda never driven", quiet_hits, 0);
        chk(out_latch == v, "R4 out_latch untouched", out_latch, v);
        i2c_start();
        wr_byte(addr_byte(0, strap, 0), ack);
        chk(ack, "R2 repeated START address ack", ack, 1);
        wr_byte(8'h5A, ack);
        chk(out_latch == 8'h5A, "R2 write after repeated START", out_latch, 8'h5A);
        i2c_stop();

        // R7: input read alternates snapshot and flags
        pa = 8'($urandom); fa = 8'($urandom);
        pb = ~pa; fb = 8'($urandom) ^ 8'h3C;
        in_port = pa; trans_flags = fa;
        c0 = n_snap;
        i2c_start();
        wr_byte(addr_byte(1, strap, 1), ack);
        chk(ack, "R3 input read address ack", ack, 1);
        rd_byte(1, rb);
        chk(rb == pa, "R7 R11 byte0 port snapshot", rb, pa);
        in_port = pb; trans_flags = fb;
        rd_byte(1, rb);
        chk(rb == fa, "R7 byte1 held flags", rb, fa);
        rd_byte(1, rb);
        chk(rb == pb, "R7 byte2 resampled port", rb, pb);
        rd_byte(0, rb);
        chk(rb == fb, "R7 byte3 flags", rb, fb);
        i2c_stop();
        chk(n_snap == c0 + 2, "R7 snap_strobe pulses", n_snap - c0, 2);

        // R8 R9: output read, then NACK silence
        out_pin_lvl = 8'hC3;
        i2c_start();
        wr_byte(addr_byte(0, strap, 1), ack);
        chk(ack, "R3 output read address ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            v = out_pin_lvl;
            rd_byte(k < 2, rb);
            chk(rb == v, "R8 output readback", rb, v);
            out_pin_lvl = 8'($urandom);
        end
        quiet_win = 1'b1;
        rd_byte(0, rb);
        quiet_win = 1'b0;
        chk(rb == 8'hFF && quiet_hits == 0, "R9 released after NACK", {quiet_hits[7:0], rb}, 16'h00FF);
        i2c_stop();

        // mixed random writes with changing straps
        for (int it = 0; it < 6; it++) begin
            bit to_in;
            int len;
            strap = 4'($urandom);
            to_in = 1'($urandom);
            len = 1 + int'($urandom_range(2));
            i2c_start();
            wr_byte(addr_byte(to_in, strap, 0), ack);
            chk(ack, "R3 random address ack", ack, 1);
            for (int k = 0; k < len; k++) begin
                v = 8'($urandom);
                wr_byte(v, ack);
                if (to_in) chk(int_mask == v, "R6 random mask", int_mask, v);
                else chk(out_latch == v, "R5 random latch", out_latch, v);
            end
            i2c_stop();
        end

        chk(r10_viol == 0, "R10 sda_oe change with SCL high", r10_viol, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule